// File: doc/BRIEF.md
# Multichannel Sampling Converter Serial Command Model

This block is a device-side digital model of a multichannel successive-approximation converter's serial port. It acts as an SPI slave (mode 0). The host sends one 16-bit command per chip-select window. The model decodes channel-select, settings-write and pin-configuration commands. It returns conversion results two frames after the frame that selected the channel. Each result carries the channel number as a tag.

Sample values come from a parallel bus that holds one word per channel. The testbench drives that bus. A 7-bit settings register holds four general-purpose pin levels, a one-shot request to read the pins back, a power-down flag and a range-doubling flag. A separate direction register decides which of the four pins are driven.

All SPI inputs are treated as synchronous to `clk`, which must run at least several times faster than `spi_sclk`. The block detects the edges of `spi_sclk` and `spi_cs_n` with registers. The next reply is loaded into the transmit shifter one clock after `spi_cs_n` falls.

Top module: `sar_spi_cmd_model`

## Requirements
- R1: A frame is accepted only if exactly 16 rising `spi_sclk` edges occur while `spi_cs_n` is low. Any other count is discarded when `spi_cs_n` rises: no register changes, the reply pipeline does not advance, and the next frame replays the same reply.
- R2: `spi_mosi` is captured on rising `spi_sclk`. `spi_miso` presents the reply MSB first, advances after each falling `spi_sclk`, and is 0 while `spi_cs_n` is high.
- R3: The channel that a frame selects is sampled from `sample_bus` when that frame ends. Its result is shifted out during the second frame after it.
- R4: A reply carries the 4-bit channel tag in bits 15:12. The RES_W-bit sample is left-justified in bits 11:0, so it fills bits 11 down to 12-RES_W, and the bits below it are 0.
- R5: A command with bit 14 = 0 and bit 12 = 1 is a select. Bits 10:7 carry the channel number. Its bits 6:0 replace the settings only when bit 11 = 1; otherwise the settings keep their value.
- R6: The settings fields are as follows. Bits 3:0 are the pin levels. Bit 5 drives `pwr_down`. Bit 6 drives `range_x2`.
- R7: If a frame leaves settings bit 4 set, the reply formed at the end of that frame carries the pin read-back levels in bits 15:12 instead of the tag. For each pin, the read-back level is the stored level if the pin is an output, and `gpio_in` if it is an input.
- R8: A command with bit 14 = 1 is a pin configuration. Its bits 3:0 become the direction register (1 = output). It takes precedence over bit 12, so the settings are not written.
- R9: A pin configuration with bit 9 = 1 clears the settings, the direction register and the held channel select, and ignores its bits 3:0.
- R10: Synchronous reset clears all registers. After reset, every pin is an input, the power and range flags are 0, and the first two replies are 0x0000.
- R11: `gpio_oe` equals the direction register. `gpio_out` carries the stored level on output pins and 0 on input pins.
- R12: A full frame with both bit 14 and bit 12 clear changes no register. It still advances the pipeline by re-sampling the held channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select, frames each word |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Command data from the host |
| spi_miso | output | 1 | Reply data to the host |
| sample_bus | input | NUM_CH*RES_W | Per-channel sample values, channel c at bits c*RES_W upward |
| gpio_in | input | 4 | Levels seen on the four pins |
| gpio_out | output | 4 | Levels driven on output pins |
| gpio_oe | output | 4 | Output enable per pin (1 = driven) |
| pwr_down | output | 1 | Power-down flag from the settings |
| range_x2 | output | 1 | Range-doubling flag from the settings |

## Verification
The bench changes `sample_bus` right after a select frame ends. A design that samples late would then return the new value instead of the captured one, and a design with one pipeline stage too few would return the result a frame early. Truncated and over-long frames carry write commands. A design that counts bits loosely would update the settings, or disturb the replayed reply. The bench also sends a command with both bit 14 and bit 12 set, which would write the settings under the wrong precedence. It also sends a read-back request with mixed pin directions, which catches a design that reads output pins from `gpio_in` or puts the tag in place of the pin levels.

// File: rtl/sar_spi_pkg.sv
package sar_spi_pkg;

    // Frame and field geometry
    localparam int FRAME_W   = 16;
    localparam int CNT_W     = 5;
    localparam int SET_W     = 7;
    localparam int PIN_N     = 4;
    localparam int TAG_W     = 4;
    localparam int BODY_W    = FRAME_W - TAG_W;
    localparam int CH_LSB    = 7;

    // Command bit positions decoded by the model
    localparam int BIT_PINCFG = 14;
    localparam int BIT_SELECT = 12;
    localparam int BIT_WREN   = 11;
    localparam int BIT_CLRALL = 9;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_SELECT = 2'd1,
        CMD_PINCFG = 2'd2
    } cmd_kind_e;

    // Packed so that the field order matches settings bits 6..0
    typedef struct packed {
        logic             range_x2;
        logic             pwr_down;
        logic             pin_snoop;
        logic [PIN_N-1:0] pin_lvl;
    } settings_t;

    typedef struct packed {
        cmd_kind_e        kind;
        logic             wr_en;
        logic [TAG_W-1:0] chan;
        settings_t        set;
        logic             clr_all;
        logic [PIN_N-1:0] dir;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [FRAME_W-1:0] w);
        cmd_t c;
        if (w[BIT_PINCFG])      c.kind = CMD_PINCFG;
        else if (w[BIT_SELECT]) c.kind = CMD_SELECT;
        else                    c.kind = CMD_NONE;
        c.wr_en   = w[BIT_WREN];
        c.chan    = w[CH_LSB +: TAG_W];
        c.set     = settings_t'(w[SET_W-1:0]);
        c.clr_all = w[BIT_CLRALL];
        c.dir     = w[PIN_N-1:0];
        return c;
    endfunction

    function automatic logic [FRAME_W-1:0] pack_reply(input logic [TAG_W-1:0]  tag,
                                                      input logic [BODY_W-1:0] body);
        return {tag, body};
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import sar_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               sclk_rise,
    input  logic               mosi,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame_word
);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (!cs_n && sclk_rise) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], mosi};
            if (bit_cnt != CNT_SAT)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_valid = cs_rise && (bit_cnt == CNT_FULL);
    assign frame_word  = rx_sh;

endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
    import sar_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_word,
    output settings_t          set_q,
    output logic [PIN_N-1:0]   dir_q,
    output logic [TAG_W-1:0]   chan_d,
    output logic               snoop_d
);
    cmd_t             cmd;
    settings_t        set_d;
    logic [PIN_N-1:0] dir_d;
    logic [TAG_W-1:0] chan_q;

    always_comb begin
        cmd    = decode_cmd(frame_word);
        set_d  = set_q;
        dir_d  = dir_q;
        chan_d = chan_q;
        unique case (cmd.kind)
            CMD_PINCFG: begin
                if (cmd.clr_all) begin
                    set_d  = '0;
                    dir_d  = '0;
                    chan_d = '0;
                end else begin
                    dir_d = cmd.dir;
                end
            end
            CMD_SELECT: begin
                chan_d = cmd.chan;
                if (cmd.wr_en)
                    set_d = cmd.set;
            end
            default: ;
        endcase
    end

    assign snoop_d = set_d.pin_snoop;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q  <= '0;
            dir_q  <= '0;
            chan_q <= '0;
        end else if (frame_valid) begin
            set_q  <= set_d;
            dir_q  <= dir_d;
            chan_q <= chan_d;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> $stable(set_q) && $stable(dir_q)); // R1

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        frame_valid && cmd.kind == CMD_SELECT && !cmd.wr_en |=> $stable(set_q)); // R5

    AST_PINCFG_SET: assert property (@(posedge clk) disable iff (rst)
        frame_valid && cmd.kind == CMD_PINCFG && !cmd.clr_all |=> $stable(set_q)); // R8

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        frame_valid && cmd.kind == CMD_PINCFG && cmd.clr_all |=> set_q == '0 && dir_q == '0); // R9

endmodule

// File: rtl/conv_pipe.sv
module conv_pipe
    import sar_spi_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_valid,
    input  logic [TAG_W-1:0]        chan_d,
    input  logic                    snoop_d,
    input  logic [PIN_N-1:0]        readback,
    input  logic [NUM_CH*RES_W-1:0] sample_bus,
    output logic [FRAME_W-1:0]      reply_q
);
    localparam int PAD_W = BODY_W - RES_W;

    logic [RES_W-1:0]  lane [NUM_CH];
    logic [RES_W-1:0]  picked;
    logic [TAG_W-1:0]  held_tag;
    logic [RES_W-1:0]  held_val;
    logic [BODY_W-1:0] body;
    logic [TAG_W-1:0]  head;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lane[g] = sample_bus[g*RES_W +: RES_W];
    end

    always_comb begin
        picked = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_d == TAG_W'(c))
                picked = lane[c];
        end
    end

    assign body = BODY_W'(held_val) << PAD_W;
    assign head = snoop_d ? readback : held_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_tag <= '0;
            held_val <= '0;
            reply_q  <= '0;
        end else if (frame_valid) begin
            reply_q  <= pack_reply(head, body);
            held_tag <= chan_d;
            held_val <= picked;
        end
    end

    AST_PIPE_TAG: assert property (@(posedge clk) disable iff (rst)
        frame_valid && !snoop_d |=> reply_q[FRAME_W-1 -: TAG_W] == $past(held_tag)); // R3

    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> $stable(reply_q)); // R1

endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
    import sar_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               cs_fall,
    input  logic               sclk_fall,
    input  logic [FRAME_W-1:0] load_word,
    output logic               miso
);
    logic [FRAME_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
        end else if (cs_fall) begin
            tx_sh <= load_word;
        end else if (!cs_n && sclk_fall) begin
            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso = !cs_n && tx_sh[FRAME_W-1];

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> tx_sh == $past(load_word)); // R2

endmodule

// File: rtl/sar_spi_cmd_model.sv
module sar_spi_cmd_model
    import sar_spi_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_cs_n,
    input  logic                    spi_sclk,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    input  logic [NUM_CH*RES_W-1:0] sample_bus,
    input  logic [PIN_N-1:0]        gpio_in,
    output logic [PIN_N-1:0]        gpio_out,
    output logic [PIN_N-1:0]        gpio_oe,
    output logic                    pwr_down,
    output logic                    range_x2
);
    logic               cs_q, sclk_q;
    logic               cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;
    settings_t          set_q;
    logic [PIN_N-1:0]   dir_q;
    logic [TAG_W-1:0]   chan_d;
    logic               snoop_d;
    logic [PIN_N-1:0]   readback;
    logic [FRAME_W-1:0] reply_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= spi_cs_n;
            sclk_q <= spi_sclk;
        end
    end

    assign cs_fall   = !spi_cs_n && cs_q;
    assign cs_rise   = spi_cs_n && !cs_q;
    assign sclk_rise = spi_sclk && !sclk_q;
    assign sclk_fall = !spi_sclk && sclk_q;

    spi_frame_rx i_rx (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (spi_cs_n),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .sclk_rise   (sclk_rise),
        .mosi        (spi_mosi),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    cmd_regs i_regs (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .set_q       (set_q),
        .dir_q       (dir_q),
        .chan_d      (chan_d),
        .snoop_d     (snoop_d)
    );

    assign readback = (dir_q & set_q.pin_lvl) | (~dir_q & gpio_in);

    conv_pipe #(.NUM_CH(NUM_CH), .RES_W(RES_W)) i_pipe (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .chan_d      (chan_d),
        .snoop_d     (snoop_d),
        .readback    (readback),
        .sample_bus  (sample_bus),
        .reply_q     (reply_q)
    );

    spi_frame_tx i_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (spi_cs_n),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall),
        .load_word (reply_q),
        .miso      (spi_miso)
    );

    assign gpio_oe  = dir_q;
    assign gpio_out = set_q.pin_lvl & dir_q;
    assign pwr_down = set_q.pwr_down;
    assign range_x2 = set_q.range_x2;

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> $stable(gpio_oe) && $stable(gpio_out)); // R11

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> $stable(pwr_down) && $stable(range_x2)); // R6

endmodule

// File: tb/test_sar_spi_cmd_model.sv
module test_sar_spi_cmd_model;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int RW   = 12;
    localparam int HALF = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [NCH*RW-1:0] samples;
    logic [3:0]        gpio_in = 4'b0000;
    logic              spi_miso, pwr_down, range_x2;
    logic [3:0]        gpio_out, gpio_oe;

    int checks = 0;
    int errors = 0;
    bit run_cmp = 1'b0;

    // behavioural reference state
    logic [6:0]  m_set = '0;
    logic [3:0]  m_dir = '0, m_chan = '0, m_tag = '0;
    logic [11:0] m_val = '0;
    logic [15:0] m_reply = '0;

    sar_spi_cmd_model #(.NUM_CH(NCH), .RES_W(RW)) i_sar_spi_cmd_model (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(spi_miso), .sample_bus(samples), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pwr_down(pwr_down), .range_x2(range_x2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sel(input logic wr, input logic [3:0] ch, input logic [6:0] s);
        return 16'h1000 | (16'(wr) << 11) | (16'(ch) << 7) | 16'(s);
    endfunction

    function automatic logic [15:0] pincfg(input logic clr, input logic [3:0] d);
        return 16'h4000 | (16'(clr) << 9) | 16'(d);
    endfunction

    task automatic fill_samples(input int seed);
        for (int c = 0; c < NCH; c++)
            samples[c*RW +: RW] = RW'(c * 273 + seed * 37 + 5);
    endtask

    task automatic model_frame(input logic [15:0] w);
        logic [6:0] ns;
        logic [3:0] nd, nc, rb;
        ns = m_set; nd = m_dir; nc = m_chan;
        rb = (m_dir & m_set[3:0]) | (~m_dir & gpio_in);
        if (w[14]) begin
            if (w[9]) begin ns = '0; nd = '0; nc = '0; end
            else nd = w[3:0];
        end else if (w[12]) begin
            nc = w[10:7];
            if (w[11]) ns = w[6:0];
        end
        m_reply = {ns[4] ? rb : m_tag, m_val};
        m_tag = nc;
        m_val = samples[nc*RW +: RW];
        m_set = ns; m_dir = nd; m_chan = nc;
    endtask

    task automatic xfer(input logic [15:0] cmd, input int nbits, input string req);
        logic [15:0] exp, got;
        exp = m_reply;
        got = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? cmd[15-i] : 1'b0;
            if (i < 16) got[15-i] = spi_miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        @(posedge clk);
        if (nbits == 16) model_frame(cmd);
        repeat (HALF) @(negedge clk);
        if (nbits >= 16) chk(req, got, exp);
    endtask

    // every-clock comparison against the reference state
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (run_cmp) begin
            chk("R11 gpio_oe", gpio_oe, m_dir);
            chk("R11 gpio_out", gpio_out, m_set[3:0] & m_dir);
            chk("R6 pwr_down", pwr_down, m_set[5]);
            chk("R6 range_x2", range_x2, m_set[6]);
            if (cs_n) chk("R2 idle miso", spi_miso, 1'b0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1..all actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill_samples(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 oe after reset", gpio_oe, 4'h0);
        chk("R10 out after reset", gpio_out, 4'h0);
        chk("R10 flags after reset", {pwr_down, range_x2}, 2'b00);
        chk("R10 miso idle", spi_miso, 1'b0);
        run_cmp = 1'b1;

        xfer(sel(0, 4'd5, 7'h00), 16, "R10 first reply zero");
        fill_samples(1);                       // ch5 already captured: R3
        xfer(sel(0, 4'd9, 7'h00), 16, "R10 second reply zero");
        fill_samples(2);
        xfer(sel(0, 4'd15, 7'h00), 16, "R3 ch5 captured at select end");
        xfer(sel(0, 4'd0, 7'h00), 16, "R4 ch9 tag and justified value");
        fill_samples(3);
        xfer(sel(0, 4'd3, 7'h00), 16, "R4 ch15 reply");
        xfer(sel(0, 4'd3, 7'h00), 16, "R4 ch0 reply");

        // R5 / R6 settings write and protected non-write
        xfer(sel(1, 4'd3, 7'h60), 16, "R5 reply during write");
        chk("R6 flags set", {pwr_down, range_x2}, 2'b11);
        xfer(sel(0, 4'd7, 7'h0F), 16, "R5 reply during no-write");
        chk("R5 settings kept", {pwr_down, range_x2}, 2'b11);

        // R8 / R11 pin directions and levels
        xfer(pincfg(0, 4'b0011), 16, "R8 reply during pincfg");
        xfer(sel(1, 4'd7, 7'h05), 16, "R11 reply");
        chk("R11 oe", gpio_oe, 4'b0011);
        chk("R11 out", gpio_out, 4'b0001);
        xfer(16'h4000 | 16'h1000 | 16'h0800 | 16'h007F, 16, "R8 priority reply");
        chk("R8 dir from pincfg", gpio_oe, 4'b1111);
        chk("R8 settings untouched", {pwr_down, range_x2, gpio_out}, {2'b00, 4'b0101});

        // R7 pin read-back one-shot
        xfer(pincfg(0, 4'b0011), 16, "R7 setup reply");
        gpio_in = 4'b1010;
        xfer(sel(1, 4'd2, 7'h15), 16, "R7 request reply");
        xfer(sel(1, 4'd2, 7'h05), 16, "R7 readback in tag 1001");
        chk("R7 readback nibble", m_reply[15:12], 4'h2);
        xfer(sel(0, 4'd2, 7'h00), 16, "R7 tag restored");

        // R12 neither mode bit
        xfer(16'h0000 | 16'h007F, 16, "R12 reply");
        chk("R12 settings unchanged", gpio_out, 4'b0001);
        fill_samples(4);
        xfer(sel(0, 4'd4, 7'h00), 16, "R12 pipeline advanced");
        xfer(sel(0, 4'd4, 7'h00), 16, "R12 resampled held channel");

        // R1 malformed frames
        xfer(sel(1, 4'd8, 7'h7F), 8, "R1 short");
        chk("R1 short ignored", {pwr_down, range_x2, gpio_out}, {2'b00, 4'b0001});
        xfer(sel(1, 4'd8, 7'h7F), 20, "R1 long frame replays reply");
        chk("R1 long ignored", {pwr_down, range_x2, gpio_out}, {2'b00, 4'b0001});
        xfer(sel(0, 4'd6, 7'h00), 16, "R1 reply after bad frames");

        // R9 clear-all
        xfer(sel(1, 4'd6, 7'h6F), 16, "R9 setup reply");
        xfer(pincfg(1, 4'b1111), 16, "R9 clear reply");
        chk("R9 cleared", {pwr_down, range_x2, gpio_oe, gpio_out}, 10'h000);
        xfer(16'h0000, 16, "R9 channel reselected to 0");
        xfer(16'h0000, 16, "R9 tag zero");

        run_cmp = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule